// File: doc/BRIEF.md
# Root Clock Generator Configuration Registers

This block is the software-facing register file of a root clock generator. Software writes a source select, a pre-divider, a counter mode and three fractional divider words (M, N, D) through a simple word-addressed bus. Those writes land only in shadow copies. The divider datapath keeps running on a separate active set, so a multi-word reconfiguration never reaches it half-written.

To commit, software sets an update request bit in the command word. The block holds that request until the downstream logic raises an apply handshake. One cycle after the handshake is seen, every shadow word moves into the active set in the same edge. The request bit then clears, and software polls it to learn that the change took effect. Per-word dirty flags show which shadow words differ from what is active.

The command word also has a force-enable bit that keeps the output clock running. Its read-only root-off flag is a synchronized view of whether anything is currently asking for the clock, either force-enable or an external request line.

Top module: `rootclk_cfg_regs`

## Requirements
- R1: After reset every register reads 0, except command bit 31 (root-off), which reads 1, and all active outputs are 0.
- R2: Writes to the configuration (byte offset 0x4), M (0x8), N (0xC) and D (0x10) words read back at once from the shadow copy, while the active outputs keep their previous values until an update is applied.
- R3: Writing 1 to command bit 0 (offset 0x0) sets the update request. Writing 0 there does not clear it, and it stays set for as long as no apply handshake arrives.
- R4: When `apply_ack` is sampled high while the update request is set, the active outputs take all shadow values at the next clock edge, and command bit 0 clears at that same edge.
- R5: `apply_ack` has no effect while no update request is pending.
- R6: Command bit 4 (configuration), bit 5 (N), bit 6 (M) and bit 7 (D) set when a write to that word carries a value different from its active value. A write equal to the active value leaves the flag unchanged.
- R7: Applying an update clears all four dirty flags.
- R8: Command bit 1 is a read/write force-enable that drives `force_on`.
- R9: Command bit 31 reads the inverse of (force-enable OR `clk_req`) through a two-flop synchronizer. A change shows two clock edges after the change is registered.
- R10: The configuration word places the pre-divider in bits PREDIV_W-1:0, the source select in 10:8, the mode in 13:12 and the hardware-control bit at 20. All other bits read 0. M, N and D keep only their low MND_W bits.
- R11: Writes to command bits 4 to 7 and bit 31 are ignored.
- R12: Reads of byte offsets above 0x10 return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| apply_ack | input | 1 | Downstream handshake: new settings may be taken |
| clk_req | input | 1 | External request to keep the root clock running |
| upd_pending | output | 1 | Update request bit (command bit 0) |
| force_on | output | 1 | Force-enable bit (command bit 1) |
| act_prediv | output | PREDIV_W | Active pre-divider |
| act_src | output | 3 | Active source select |
| act_mode | output | 2 | Active counter mode |
| act_hwctl | output | 1 | Active hardware-control bit |
| act_m | output | MND_W | Active M word |
| act_n | output | MND_W | Active N word |
| act_d | output | MND_W | Active D word |

## Verification
The assertions check four things on every cycle. The active set stays frozen unless a commit occurs. The update request never drops without a handshake two cycles earlier, and it never drops on its own. The dirty flags are all clear after a commit with no competing write. Root-off is low whenever force-enable or the clock request has been steady high for two cycles. Field placement, masking of unused bits, the equal-value dirty rule, read-only and unmapped-address behaviour, and the exact edge at which outputs change can only be shown by the bench's scenarios, which read the registers back and compare them with the expected values.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    // Word indices (byte offset / 4); the decode order is fixed by software
    localparam int unsigned WI_CMD = 0;
    localparam int unsigned WI_CFG = 1;
    localparam int unsigned WI_M   = 2;
    localparam int unsigned WI_N   = 3;
    localparam int unsigned WI_D   = 4;

    // Command word bit positions
    localparam int unsigned UPD_BIT     = 0;
    localparam int unsigned FORCE_BIT   = 1;
    localparam int unsigned DIRTY_CFG   = 4;
    localparam int unsigned DIRTY_N     = 5;
    localparam int unsigned DIRTY_M     = 6;
    localparam int unsigned DIRTY_D     = 7;
    localparam int unsigned ROOTOFF_BIT = 31;

    // Configuration word field positions
    localparam int unsigned SRC_LSB   = 8;
    localparam int unsigned MODE_LSB  = 12;
    localparam int unsigned HWCTL_BIT = 20;
    localparam int unsigned PREDIV_MAX_W = 8;

    localparam int unsigned NUM_MND = 3;

    // Index of each fractional word inside the packed M/N/D arrays
    typedef enum int unsigned {
        MND_M = 0,
        MND_N = 1,
        MND_D = 2
    } mnd_sel_e;

    typedef struct packed {
        logic                    hwctl;
        logic [1:0]              mode;
        logic [2:0]              src;
        logic [PREDIV_MAX_W-1:0] prediv;
    } cfg_t;

    function automatic cfg_t word_to_cfg(input logic [31:0] w, input int pw);
        cfg_t c;
        c.prediv = '0;
        for (int i = 0; i < int'(PREDIV_MAX_W); i++) begin
            if (i < pw) c.prediv[i] = w[i];
        end
        c.src   = w[SRC_LSB +: 3];
        c.mode  = w[MODE_LSB +: 2];
        c.hwctl = w[HWCTL_BIT];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input cfg_t c);
        logic [31:0] w;
        w = '0;
        w[PREDIV_MAX_W-1:0] = c.prediv;
        w[SRC_LSB +: 3]     = c.src;
        w[MODE_LSB +: 2]    = c.mode;
        w[HWCTL_BIT]        = c.hwctl;
        return w;
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkcfg_shadow.sv
module clkcfg_shadow
    import clkcfg_pkg::*;
#(
    parameter int MND_W    = 16,
    parameter int PREDIV_W = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_cfg,
    input  logic [NUM_MND-1:0]              wr_mnd,
    input  logic [31:0]                     wdata,
    input  cfg_t                            act_cfg,
    input  logic [NUM_MND-1:0][MND_W-1:0]   act_mnd,
    input  logic                            commit,
    output cfg_t                            shd_cfg,
    output logic [NUM_MND-1:0][MND_W-1:0]   shd_mnd,
    output logic                            dirty_cfg,
    output logic [NUM_MND-1:0]              dirty_mnd
);
    cfg_t              wr_cfg_val;
    logic [MND_W-1:0]  wr_mnd_val;

    assign wr_cfg_val = word_to_cfg(wdata, PREDIV_W);
    assign wr_mnd_val = wdata[MND_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg   <= '0;
            dirty_cfg <= 1'b0;
        end else begin
            if (wr_cfg) shd_cfg <= wr_cfg_val;
            if (wr_cfg && (wr_cfg_val != act_cfg)) dirty_cfg <= 1'b1;
            else if (commit)                       dirty_cfg <= 1'b0;
        end
    end

    generate
        for (genvar g = 0; g < int'(NUM_MND); g++) begin : g_mnd
            always_ff @(posedge clk) begin
                if (rst) begin
                    shd_mnd[g]   <= '0;
                    dirty_mnd[g] <= 1'b0;
                end else begin
                    if (wr_mnd[g]) shd_mnd[g] <= wr_mnd_val;
                    if (wr_mnd[g] && (wr_mnd_val != act_mnd[g])) dirty_mnd[g] <= 1'b1;
                    else if (commit)                             dirty_mnd[g] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/clkcfg_commit.sv
module clkcfg_commit
    import clkcfg_pkg::*;
#(
    parameter int MND_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_set,
    input  logic                            apply_ack,
    input  cfg_t                            shd_cfg,
    input  logic [NUM_MND-1:0][MND_W-1:0]   shd_mnd,
    output logic                            upd_pending,
    output logic                            commit,
    output cfg_t                            act_cfg,
    output logic [NUM_MND-1:0][MND_W-1:0]   act_mnd
);
    logic ack_q;

    // Handshake is registered; the copy happens on the following edge.
    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= apply_ack && upd_pending && !ack_q;
    end

    assign commit = ack_q;

    always_ff @(posedge clk) begin
        if (rst)          upd_pending <= 1'b0;
        else if (req_set) upd_pending <= 1'b1;
        else if (commit)  upd_pending <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg <= '0;
            act_mnd <= '0;
        end else if (commit) begin
            act_cfg <= shd_cfg;
            act_mnd <= shd_mnd;
        end
    end
endmodule

// File: rtl/rootclk_cfg_regs.sv
module rootclk_cfg_regs
    import clkcfg_pkg::*;
#(
    parameter int MND_W       = 16,
    parameter int PREDIV_W    = 5,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                apply_ack,
    input  logic                clk_req,
    output logic                upd_pending,
    output logic                force_on,
    output logic [PREDIV_W-1:0] act_prediv,
    output logic [2:0]          act_src,
    output logic [1:0]          act_mode,
    output logic                act_hwctl,
    output logic [MND_W-1:0]    act_m,
    output logic [MND_W-1:0]    act_n,
    output logic [MND_W-1:0]    act_d
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]             word_idx;
    logic                          wr;
    logic                          wr_cmd;
    logic                          wr_cfg;
    logic [NUM_MND-1:0]            wr_mnd;
    cfg_t                          shd_cfg;
    cfg_t                          act_cfg;
    logic [NUM_MND-1:0][MND_W-1:0] shd_mnd;
    logic [NUM_MND-1:0][MND_W-1:0] act_mnd;
    logic                          dirty_cfg;
    logic [NUM_MND-1:0]            dirty_mnd;
    logic                          commit_pulse;
    logic                          force_q;
    logic                          root_off;
    logic                          off_raw;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign wr       = bus_en && bus_we;
    assign wr_cmd   = wr && (word_idx == WIDX_W'(WI_CMD));
    assign wr_cfg   = wr && (word_idx == WIDX_W'(WI_CFG));

    generate
        for (genvar g = 0; g < int'(NUM_MND); g++) begin : g_dec
            assign wr_mnd[g] = wr && (word_idx == WIDX_W'(WI_M + g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         force_q <= 1'b0;
        else if (wr_cmd) force_q <= bus_wdata[FORCE_BIT];
    end

    clkcfg_shadow #(.MND_W(MND_W), .PREDIV_W(PREDIV_W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_cfg    (wr_cfg),
        .wr_mnd    (wr_mnd),
        .wdata     (bus_wdata),
        .act_cfg   (act_cfg),
        .act_mnd   (act_mnd),
        .commit    (commit_pulse),
        .shd_cfg   (shd_cfg),
        .shd_mnd   (shd_mnd),
        .dirty_cfg (dirty_cfg),
        .dirty_mnd (dirty_mnd)
    );

    clkcfg_commit #(.MND_W(MND_W)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .req_set     (wr_cmd && bus_wdata[UPD_BIT]),
        .apply_ack   (apply_ack),
        .shd_cfg     (shd_cfg),
        .shd_mnd     (shd_mnd),
        .upd_pending (upd_pending),
        .commit      (commit_pulse),
        .act_cfg     (act_cfg),
        .act_mnd     (act_mnd)
    );

    assign off_raw = !(force_q || clk_req);

    clkcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (off_raw),
        .q   (root_off)
    );

    always_comb begin
        bus_rdata = '0;
        if (word_idx == WIDX_W'(WI_CMD)) begin
            bus_rdata[UPD_BIT]     = upd_pending;
            bus_rdata[FORCE_BIT]   = force_q;
            bus_rdata[DIRTY_CFG]   = dirty_cfg;
            bus_rdata[DIRTY_N]     = dirty_mnd[MND_N];
            bus_rdata[DIRTY_M]     = dirty_mnd[MND_M];
            bus_rdata[DIRTY_D]     = dirty_mnd[MND_D];
            bus_rdata[ROOTOFF_BIT] = root_off;
        end else if (word_idx == WIDX_W'(WI_CFG)) begin
            bus_rdata = cfg_to_word(shd_cfg);
        end else if (word_idx == WIDX_W'(WI_M)) begin
            bus_rdata[MND_W-1:0] = shd_mnd[MND_M];
        end else if (word_idx == WIDX_W'(WI_N)) begin
            bus_rdata[MND_W-1:0] = shd_mnd[MND_N];
        end else if (word_idx == WIDX_W'(WI_D)) begin
            bus_rdata[MND_W-1:0] = shd_mnd[MND_D];
        end
    end

    assign force_on   = force_q;
    assign act_prediv = act_cfg.prediv[PREDIV_W-1:0];
    assign act_src    = act_cfg.src;
    assign act_mode   = act_cfg.mode;
    assign act_hwctl  = act_cfg.hwctl;
    assign act_m      = act_mnd[MND_M];
    assign act_n      = act_mnd[MND_N];
    assign act_d      = act_mnd[MND_D];
endmodule

// File: rtl/rootclk_cfg_regs_chk.sv
module rootclk_cfg_regs_chk #(
    parameter int MND_W    = 16,
    parameter int PREDIV_W = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_en,
    input logic                bus_we,
    input logic                apply_ack,
    input logic                clk_req,
    input logic                upd_pending,
    input logic                commit,
    input logic                force_on,
    input logic                root_off,
    input logic [3:0]          dirty,
    input logic [PREDIV_W-1:0] act_prediv,
    input logic [2:0]          act_src,
    input logic [1:0]          act_mode,
    input logic                act_hwctl,
    input logic [MND_W-1:0]    act_m,
    input logic [MND_W-1:0]    act_n,
    input logic [MND_W-1:0]    act_d
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    wire settled = (since_rst >= 2'd2);

    // R2: the active set moves only on a commit
    assert_act_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable({act_prediv, act_src, act_mode, act_hwctl, act_m, act_n, act_d}));

    // R3: the request never drops without a commit
    assert_upd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_pending && !commit) |=> upd_pending);

    // R4: clearing of the request follows a handshake two samples back
    assert_upd_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pending) |-> $past(apply_ack, 2));

    // R7: a commit with no competing write leaves no dirty flag
    assert_dirty_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && !(bus_en && bus_we)) |=> (dirty == 4'b0000));

    // R9: steady force-enable keeps root-off low
    assert_rootoff_force_R9: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(force_on) && $past(force_on, 2)) |-> !root_off);

    // R9: steady clock request keeps root-off low
    assert_rootoff_req_R9: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(clk_req) && $past(clk_req, 2)) |-> !root_off);
endmodule

bind rootclk_cfg_regs rootclk_cfg_regs_chk #(.MND_W(MND_W), .PREDIV_W(PREDIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .apply_ack   (apply_ack),
    .clk_req     (clk_req),
    .upd_pending (upd_pending),
    .commit      (commit_pulse),
    .force_on    (force_on),
    .root_off    (root_off),
    .dirty       ({dirty_mnd[2], dirty_mnd[0], dirty_mnd[1], dirty_cfg}),
    .act_prediv  (act_prediv),
    .act_src     (act_src),
    .act_mode    (act_mode),
    .act_hwctl   (act_hwctl),
    .act_m       (act_m),
    .act_n       (act_n),
    .act_d       (act_d)
);

// File: tb/rootclk_cfg_regs_bench.sv
module rootclk_cfg_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MND_W      = 16;
    localparam int PREDIV_W   = 5;
    localparam int ADDR_W     = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bus_en = 1'b0;
    logic                bus_we = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                apply_ack = 1'b0;
    logic                clk_req = 1'b0;
    logic                upd_pending;
    logic                force_on;
    logic [PREDIV_W-1:0] act_prediv;
    logic [2:0]          act_src;
    logic [1:0]          act_mode;
    logic                act_hwctl;
    logic [MND_W-1:0]    act_m;
    logic [MND_W-1:0]    act_n;
    logic [MND_W-1:0]    act_d;

    int  compared   = 0;
    int  mismatched = 0;
    bit  finished   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rootclk_cfg_regs #(.MND_W(MND_W), .PREDIV_W(PREDIV_W), .ADDR_W(ADDR_W)) u_rootclk_cfg_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .apply_ack(apply_ack),
        .clk_req(clk_req), .upd_pending(upd_pending), .force_on(force_on),
        .act_prediv(act_prediv), .act_src(act_src), .act_mode(act_mode),
        .act_hwctl(act_hwctl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
    );

    // Observation selectors
    localparam int OBS_RD  = 0;
    localparam int OBS_CFG = 1;
    localparam int OBS_M   = 2;
    localparam int OBS_N   = 3;
    localparam int OBS_D   = 4;
    localparam int OBS_FRC = 5;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            OBS_RD:  return bus_rdata;
            OBS_CFG: return {11'b0, act_hwctl, 6'b0, act_mode, 1'b0, act_src, 3'b0, act_prediv};
            OBS_M:   return {16'b0, act_m};
            OBS_N:   return {16'b0, act_n};
            OBS_D:   return {16'b0, act_d};
            default: return {31'b0, force_on};
        endcase
    endfunction

    // Monitor: compares every expectation queued in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = sb.pop_front();
            got = observe(it.sel);
            compared++;
            if (got !== it.exp) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic push(input int sel, input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        item_t it;
        if (sel == OBS_RD) bus_addr = a;
        it.sel = sel; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic expect_now(input int sel, input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        push(sel, a, e, t);
    endtask

    task automatic expect_next(input int sel, input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        push(sel, a, e, t);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(3);

        // R1: reset state
        expect_now (OBS_RD, 5'h00, 32'h8000_0000, "R1 cmd");
        expect_next(OBS_RD, 5'h04, 32'h0, "R1 cfg");
        expect_next(OBS_RD, 5'h0C, 32'h0, "R1 n");
        expect_next(OBS_CFG, 5'h0, 32'h0, "R1 act cfg");

        // R10/R2/R6: configuration word masking and shadowing
        wr(5'h04, 32'hFFFF_FFFF);
        expect_now (OBS_RD, 5'h04, 32'h0010_371F, "R10 cfg fields");
        expect_next(OBS_CFG, 5'h0, 32'h0, "R2 act cfg held");
        expect_next(OBS_RD, 5'h00, 32'h8000_0010, "R6 cfg dirty");

        wr(5'h08, 32'h0001_2345);
        wr(5'h0C, 32'h0000_0000);
        expect_now (OBS_RD, 5'h00, 32'h8000_0050, "R6 equal N no dirty");
        wr(5'h10, 32'h0000_ABCD);
        expect_now (OBS_RD, 5'h00, 32'h8000_00D0, "R6 D dirty");
        expect_next(OBS_RD, 5'h08, 32'h0000_2345, "R10 M masked");
        expect_next(OBS_RD, 5'h10, 32'h0000_ABCD, "R2 D readback");
        expect_next(OBS_M, 5'h0, 32'h0, "R2 act m held");

        // R11: read-only command bits
        wr(5'h00, 32'h8000_00F0);
        expect_now (OBS_RD, 5'h00, 32'h8000_00D0, "R11 ro bits");

        // R5: handshake with nothing pending
        @(posedge clk); #1 apply_ack = 1'b1;
        @(posedge clk); #1 apply_ack = 1'b0;
        idle(2);
        expect_now (OBS_CFG, 5'h0, 32'h0, "R5 act cfg");
        expect_next(OBS_D, 5'h0, 32'h0, "R5 act d");
        expect_next(OBS_RD, 5'h00, 32'h8000_00D0, "R5 cmd");

        // R3: request set, sticky, not cleared by writing 0
        wr(5'h00, 32'h0000_0001);
        expect_now (OBS_RD, 5'h00, 32'h8000_00D1, "R3 set");
        idle(5);
        wr(5'h00, 32'h0000_0000);
        expect_now (OBS_RD, 5'h00, 32'h8000_00D1, "R3 sticky");

        // R4/R7: apply
        @(posedge clk); #1 apply_ack = 1'b1;
        @(posedge clk); #1 apply_ack = 1'b0;
        expect_now (OBS_M, 5'h0, 32'h0, "R4 not yet applied");
        expect_now (OBS_RD, 5'h00, 32'h8000_00D1, "R4 still pending");
        @(posedge clk); #1;
        push(OBS_CFG, 5'h0, 32'h0010_371F, "R4 act cfg");
        push(OBS_M, 5'h0, 32'h0000_2345, "R4 act m");
        push(OBS_N, 5'h0, 32'h0, "R4 act n");
        push(OBS_D, 5'h0, 32'h0000_ABCD, "R4 act d");
        push(OBS_RD, 5'h00, 32'h8000_0000, "R7 dirty and req cleared");

        // R6: equal write after commit, then differing N
        wr(5'h08, 32'h0000_2345);
        expect_now (OBS_RD, 5'h00, 32'h8000_0000, "R6 equal M");
        wr(5'h0C, 32'h0000_0001);
        expect_now (OBS_RD, 5'h00, 32'h8000_0020, "R6 N dirty");

        // R12: unmapped space
        wr(5'h14, 32'hFFFF_FFFF);
        expect_now (OBS_RD, 5'h14, 32'h0, "R12 read 0x14");
        expect_next(OBS_RD, 5'h18, 32'h0, "R12 read 0x18");
        expect_next(OBS_RD, 5'h00, 32'h8000_0020, "R12 cmd untouched");
        expect_next(OBS_RD, 5'h04, 32'h0010_371F, "R12 cfg untouched");

        // R4 second commit
        wr(5'h00, 32'h0000_0001);
        @(posedge clk); #1 apply_ack = 1'b1;
        @(posedge clk); #1 apply_ack = 1'b0;
        expect_next(OBS_N, 5'h0, 32'h0000_0001, "R4 act n second");
        expect_now (OBS_RD, 5'h00, 32'h8000_0000, "R7 second clear");

        // R8/R9: force-enable and synchronized root-off
        wr(5'h00, 32'h0000_0002);
        expect_now (OBS_FRC, 5'h0, 32'h1, "R8 force_on");
        expect_now (OBS_RD, 5'h00, 32'h8000_0002, "R9 off still 1");
        expect_next(OBS_RD, 5'h00, 32'h8000_0002, "R9 one edge");
        expect_next(OBS_RD, 5'h00, 32'h0000_0002, "R9 two edges");

        clk_req = 1'b1;
        wr(5'h00, 32'h0000_0000);
        idle(3);
        expect_now (OBS_FRC, 5'h0, 32'h0, "R8 force cleared");
        expect_now (OBS_RD, 5'h00, 32'h0000_0000, "R9 req keeps on");
        clk_req = 1'b0;
        expect_next(OBS_RD, 5'h00, 32'h0000_0000, "R9 req one edge");
        expect_next(OBS_RD, 5'h00, 32'h8000_0000, "R9 req two edges");

        idle(3);
        finished = 1;
        summary();
        $finish;
    end
endmodule